// File: doc/BRIEF.md
# Byte-Fed I2S Stereo Transmitter

This block turns a stream of bytes into an I2S transmit link. The bit clock `clk` drives a free-running position counter, and every output is a register or a decode of it. The top bit of that counter is the channel line. Its low bits set a byte boundary every eight bit clocks. At each boundary one byte goes into an eight-bit parallel-in/serial-out register, which shifts it out most significant bit first, with zeros filling in behind. Four bytes in a row make one 32-bit slot. The bit clock goes out as `sclk`, the inverse of `clk`. So every data and channel change lands on a falling `sclk` edge, and the receiver samples on the rising one.

The upstream source, usually a small FIFO, is paced by `byte_req`. The block never waits: the capture rate is fixed by the counter. A request is a one-cycle pulse, and the source answers it in the following cycle with `byte_data` and `byte_valid`. That is the only back-pressure rule. The source has one cycle to respond, and a missing byte (`byte_valid` low) is sent as zeros rather than stalling the link.

When mirroring is on (the default), only the left slot pulls bytes from the source. The right slot replays the same four bytes from a small store. After a synchronous reset is released, a short run of silent slots lets the framing settle before the first request is made.

Top module: `i2s_byte_serializer`

## Requirements
- R1: `sclk` is the logical inverse of `clk`, so `ws` and `sdata`, which update on rising `clk`, change on falling `sclk`.
- R2: `ws` is low for 32 bit clocks (left slot) and then high for 32 bit clocks (right slot). The first slot after reset release is a left slot.
- R3: Each slot word is 32 bits, sent MSB first. The MSB appears one bit clock after the `ws` transition that opens the slot, and the LSB is sent in the bit clock in which `ws` toggles again.
- R4: The first byte captured for a slot becomes bits 31..24 of the word, and the fourth captured byte becomes bits 7..0.
- R5: `byte_req` is a single-cycle pulse. `byte_data` and `byte_valid` are captured at the end of the cycle that follows it, and consecutive captures are eight bit clocks apart.
- R6: If `byte_valid` is low at a capture, that byte is sent as 8'h00 and `byte_data` is ignored.
- R7: After reset release, the first three slots are all zero and no `byte_req` is issued during them. With mirroring, the first request comes in bit clock 127 after release (bit clock 0 being the first cycle with reset low), one cycle before the first left slot after the silent run begins loading.
- R8: With mirroring, each right slot carries the same 32-bit word as the left slot just before it, and `byte_req` is issued only for left-slot bytes (four per frame).
- R9: While `rst` is high, `ws`, `sdata` and `byte_req` are held low. A reset in mid-stream restarts framing with the silent slots and then a left slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; all state updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset that aligns the framing |
| byte_data | input | 8 | Byte presented in the cycle after a request |
| byte_valid | input | 1 | Marks `byte_data` as real data; low means send zeros |
| byte_req | output | 1 | One-cycle request for the next byte |
| sclk | output | 1 | Serial clock, inverse of `clk` |
| ws | output | 1 | Word select: 0 left, 1 right |
| sdata | output | 1 | Serial data, MSB first |

## Verification
The assertions rely on a few things about the inputs. They take `rst` to be synchronous to `clk`. They give `byte_valid` meaning only in the capture cycle that follows a request, and they never expect the source to hold off the link. The bench drives every input a fixed delay after a rising edge. It presents each byte exactly one cycle after it sees a request and drops `byte_valid` in every other cycle. So no capture sees stale or half-changed data, and the deliberately invalid table bytes are the only underruns apart from the idle tail. The bench applies a mid-stream reset only a short delay after a rising edge and holds it across a full clock, so each restart starts from a clean counter state.

// File: rtl/i2s_ser_pkg.sv
package i2s_ser_pkg;

  // Where the byte for the next capture comes from
  typedef enum logic [1:0] {
    SRC_ZERO   = 2'd0,  // silent start-up slot
    SRC_INPUT  = 2'd1,  // fresh byte from the upstream bus
    SRC_REPLAY = 2'd2   // stored copy of the left-slot byte
  } byte_src_e;

endpackage

// File: rtl/i2s_slot_timer.sv
module i2s_slot_timer
  import i2s_ser_pkg::*;
#(
  parameter int BYTE_W     = 8,
  parameter int SLOT_BYTES = 4,
  parameter int ZERO_SLOTS = 3,
  parameter bit MIRROR     = 1'b1,
  localparam int SLOT_W    = BYTE_W * SLOT_BYTES,
  localparam int BIT_LW    = $clog2(BYTE_W),
  localparam int SLOT_LW   = $clog2(SLOT_W),
  localparam int IDX_W     = SLOT_LW - BIT_LW
) (
  input  logic             clk,
  input  logic             rst,
  output logic             ws,
  output logic             load,
  output logic [IDX_W-1:0] byte_idx,
  output byte_src_e        src,
  output logic             byte_req
);

  localparam int CNT_W = SLOT_LW + 1;
  localparam int ZC_W  = $clog2(ZERO_SLOTS + 2);
  localparam logic [ZC_W-1:0] ZC_LIMIT = ZC_W'(ZERO_SLOTS);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_next;
  logic [ZC_W-1:0]  zc;
  logic [ZC_W-1:0]  zc_after;
  logic             slot_end;
  logic             quiet_now;
  logic             quiet_next;
  logic             pre_load;

  assign cnt_next = cnt + CNT_W'(1);
  assign slot_end = &cnt[SLOT_LW-1:0];

  // Position counter plus a saturating count of slots since reset
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      zc  <= '0;
    end else begin
      cnt <= cnt_next;
      zc  <= zc_after;
    end
  end

  assign zc_after   = (slot_end && (zc != ZC_LIMIT)) ? zc + ZC_W'(1) : zc;
  assign quiet_now  = (zc < ZC_LIMIT);
  assign quiet_next = (zc_after < ZC_LIMIT);

  assign ws       = cnt[CNT_W-1];
  assign load     = (cnt[BIT_LW-1:0] == '0);
  assign pre_load = (&cnt[BIT_LW-1:0]);
  assign byte_idx = cnt[SLOT_LW-1:BIT_LW];

  // Source choice for the capture happening at the end of this cycle
  always_comb begin
    if (quiet_now)          src = SRC_ZERO;
    else if (MIRROR && ws)  src = SRC_REPLAY;
    else                    src = SRC_INPUT;
  end

  // Request is raised one cycle ahead of a capture that takes a fresh byte
  assign byte_req = pre_load && !quiet_next && !(MIRROR && cnt_next[CNT_W-1]);

endmodule

// File: rtl/i2s_byte_source.sv
module i2s_byte_source
  import i2s_ser_pkg::*;
#(
  parameter int BYTE_W     = 8,
  parameter int SLOT_BYTES = 4,
  parameter bit MIRROR     = 1'b1,
  localparam int IDX_W     = $clog2(SLOT_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  byte_src_e         src,
  input  logic [IDX_W-1:0]  byte_idx,
  input  logic [BYTE_W-1:0] byte_data,
  input  logic              byte_valid,
  output logic              take,
  output logic [BYTE_W-1:0] byte_out
);

  logic [BYTE_W-1:0] in_byte;
  logic [BYTE_W-1:0] replay;

  assign take    = load && (src == SRC_INPUT);
  assign in_byte = byte_valid ? byte_data : '0;

  generate
    if (MIRROR) begin : g_store
      logic [BYTE_W-1:0] store [SLOT_BYTES];
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int i = 0; i < SLOT_BYTES; i++) store[i] <= '0;
        end else if (take) begin
          store[byte_idx] <= in_byte;
        end
      end
      assign replay = store[byte_idx];
    end else begin : g_no_store
      assign replay = '0;
    end
  endgenerate

  always_comb begin
    unique case (src)
      SRC_INPUT:  byte_out = in_byte;
      SRC_REPLAY: byte_out = replay;
      default:    byte_out = '0;
    endcase
  end

endmodule

// File: rtl/i2s_piso.sv
module i2s_piso #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [BYTE_W-1:0] din,
  output logic              sout
);

  logic [BYTE_W-1:0] sh;

  // Parallel load wins; otherwise shift toward the MSB with zero fill
  always_ff @(posedge clk) begin
    if (rst)       sh <= '0;
    else if (load) sh <= din;
    else           sh <= {sh[BYTE_W-2:0], 1'b0};
  end

  assign sout = sh[BYTE_W-1];

endmodule

// File: rtl/i2s_byte_serializer.sv
module i2s_byte_serializer
  import i2s_ser_pkg::*;
#(
  parameter int BYTE_W     = 8,
  parameter int SLOT_BYTES = 4,
  parameter int ZERO_SLOTS = 3,
  parameter bit MIRROR     = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BYTE_W-1:0] byte_data,
  input  logic              byte_valid,
  output logic              byte_req,
  output logic              sclk,
  output logic              ws,
  output logic              sdata
);

  localparam int SLOT_W = BYTE_W * SLOT_BYTES;
  localparam int IDX_W  = $clog2(SLOT_BYTES);

  logic              load;
  logic              take;
  logic [IDX_W-1:0]  byte_idx;
  byte_src_e         src;
  logic [BYTE_W-1:0] next_byte;

  i2s_slot_timer #(
    .BYTE_W     (BYTE_W),
    .SLOT_BYTES (SLOT_BYTES),
    .ZERO_SLOTS (ZERO_SLOTS),
    .MIRROR     (MIRROR)
  ) u_timer (
    .clk      (clk),
    .rst      (rst),
    .ws       (ws),
    .load     (load),
    .byte_idx (byte_idx),
    .src      (src),
    .byte_req (byte_req)
  );

  i2s_byte_source #(
    .BYTE_W     (BYTE_W),
    .SLOT_BYTES (SLOT_BYTES),
    .MIRROR     (MIRROR)
  ) u_source (
    .clk        (clk),
    .rst        (rst),
    .load       (load),
    .src        (src),
    .byte_idx   (byte_idx),
    .byte_data  (byte_data),
    .byte_valid (byte_valid),
    .take       (take),
    .byte_out   (next_byte)
  );

  i2s_piso #(
    .BYTE_W (BYTE_W)
  ) u_piso (
    .clk  (clk),
    .rst  (rst),
    .load (load),
    .din  (next_byte),
    .sout (sdata)
  );

  // Serial clock leaves inverted so register updates fall on its falling edge
  assign sclk = ~clk;

endmodule

// File: rtl/i2s_byte_serializer_chk.sv
module i2s_byte_serializer_chk #(
  parameter int SLOT_W     = 32,
  parameter int ZERO_SLOTS = 3,
  parameter bit MIRROR     = 1'b1
) (
  input logic clk,
  input logic rst,
  input logic ws,
  input logic sdata,
  input logic byte_req,
  input logic byte_valid,
  input logic load,
  input logic take
);

  localparam int FIRST_LEFT = (MIRROR && (ZERO_SLOTS % 2 != 0)) ? ZERO_SLOTS + 1 : ZERO_SLOTS;
  localparam int FIRST_REQ  = (FIRST_LEFT * SLOT_W > 0) ? FIRST_LEFT * SLOT_W - 1 : 0;
  localparam int AGE_W      = $clog2(FIRST_REQ + 2);
  localparam int RUN_W      = $clog2(SLOT_W) + 1;

  logic [AGE_W-1:0] age;
  logic [RUN_W-1:0] run;
  logic             ws_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      age  <= '0;
      run  <= '0;
      ws_q <= 1'b0;
    end else begin
      if (age != AGE_W'(FIRST_REQ + 1)) age <= age + AGE_W'(1);
      run  <= (ws != ws_q) ? RUN_W'(1) : run + RUN_W'(1);
      ws_q <= ws;
    end
  end

  // R2: every channel slot lasts exactly SLOT_W bit clocks
  a_r2_slot_length: assert property (@(posedge clk) disable iff (rst)
    (ws != ws_q) |-> (run == RUN_W'(SLOT_W)));

  // R5: request is a single pulse and the following cycle is a capture
  a_r5_req_then_load: assert property (@(posedge clk) disable iff (rst)
    byte_req |=> (load && !byte_req));

  // R6: an unfilled capture puts a zero MSB on the line next cycle
  a_r6_underrun_zero: assert property (@(posedge clk) disable iff (rst)
    (take && !byte_valid) |=> !sdata);

  // R7: no request during the silent start-up window
  a_r7_quiet_start: assert property (@(posedge clk) disable iff (rst)
    byte_req |-> (age >= AGE_W'(FIRST_REQ)));

  // R9: reset forces the outputs low
  a_r9_reset_idle: assert property (@(posedge clk)
    rst |=> (!ws && !sdata && !byte_req));

  generate
    if (MIRROR) begin : g_mirror_chk
      // R8: requests only serve left-slot captures
      a_r8_left_only: assert property (@(posedge clk) disable iff (rst)
        byte_req |=> !ws);
    end
  endgenerate

endmodule

bind i2s_byte_serializer i2s_byte_serializer_chk #(
  .SLOT_W     (SLOT_W),
  .ZERO_SLOTS (ZERO_SLOTS),
  .MIRROR     (MIRROR)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .ws         (ws),
  .sdata      (sdata),
  .byte_req   (byte_req),
  .byte_valid (byte_valid),
  .load       (load),
  .take       (take)
);

// File: tb/i2s_byte_serializer_bench.sv
`timescale 1ns/1ps
module i2s_byte_serializer_bench;

  localparam int N_VEC      = 8;
  localparam int PAD_SLOTS  = 4;    // three silent slots plus the mirrored fourth
  localparam int FIRST_REQ  = 127;  // bit clock of the first request after release
  localparam int EXTRA      = 2;

  // {valid mask (bit 3 = first/most significant byte), 32-bit sample}
  localparam logic [35:0] VEC [N_VEC] = '{
    {4'hF, 32'h8000_0001},
    {4'hF, 32'hFFFF_FFFF},
    {4'hF, 32'h0000_0000},
    {4'hF, 32'hA5C3_3C5A},
    {4'hB, 32'h1234_5678},
    {4'hF, 32'h7F80_01FE},
    {4'h0, 32'hDEAD_BEEF},
    {4'hF, 32'h0123_4567}
  };

  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] byte_data;
  logic       byte_valid;
  logic       byte_req;
  logic       sclk;
  logic       ws;
  logic       sdata;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;

  i2s_byte_serializer u_i2s_byte_serializer (
    .clk        (clk),
    .rst        (rst),
    .byte_data  (byte_data),
    .byte_valid (byte_valid),
    .byte_req   (byte_req),
    .sclk       (sclk),
    .ws         (ws),
    .sdata      (sdata)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] masked(input int e);
    logic [31:0] w;
    w = VEC[e][31:0];
    for (int b = 0; b < 4; b++)
      if (!VEC[e][35-b]) w[31-8*b -: 8] = 8'h00;
    return w;
  endfunction

  function automatic logic [31:0] exp_word(input int k);
    int e;
    if (k < PAD_SLOTS) return 32'h0;
    e = (k - PAD_SLOTS) / 2;
    if (e >= N_VEC) return 32'h0;
    return masked(e);
  endfunction

  function automatic string word_tag(input int k);
    if (k < PAD_SLOTS) return "R7 silent slot";
    if ((k - PAD_SLOTS) / 2 < N_VEC && VEC[(k - PAD_SLOTS) / 2][35:32] != 4'hF) return "R6 underrun bytes";
    if (k % 2 == 1) return "R8 mirrored right word";
    return "R4 left word from bytes";
  endfunction

  // Receiver: samples on rising sclk (falling clk)
  int          nsamp, nbits, rx_idx;
  logic        prev_ws;
  logic [31:0] acc;
  bit          first_req_done;

  always @(negedge clk) begin
    if (rst) begin
      nsamp = 0; nbits = 0; rx_idx = 0; prev_ws = 1'b0; acc = '0; first_req_done = 1'b0;
    end else begin
      if (nsamp != 0) begin
        acc = {acc[30:0], sdata};
        nbits++;
        if (ws != prev_ws) begin
          check(nbits == 32, "R3 bits per slot", nbits, 32);
          check(prev_ws == rx_idx[0], "R2 channel order", prev_ws, rx_idx[0]);
          check(acc == exp_word(rx_idx), word_tag(rx_idx), acc, exp_word(rx_idx));
          rx_idx++;
          nbits = 0;
        end
        prev_ws = ws;
      end
      if (byte_req && !first_req_done) begin
        check(nsamp == FIRST_REQ, "R7 first request cycle", nsamp, FIRST_REQ);
        first_req_done = 1'b1;
      end
      nsamp++;
    end
  end

  // Walk the vector table, answering each request in the following cycle
  task automatic feed_table();
    for (int i = 0; i < N_VEC; i++) begin
      for (int b = 0; b < 4; b++) begin
        do begin
          @(posedge clk); #2;
          byte_valid = 1'b0;
          byte_data  = 8'hC3;
        end while (!byte_req);
        @(posedge clk); #2;
        check(byte_req == 1'b0, "R5 request is one cycle", byte_req, 0);
        byte_data  = VEC[i][31-8*b -: 8];
        byte_valid = VEC[i][35-b];
      end
    end
    @(posedge clk); #2;
    byte_valid = 1'b0;
  endtask

  task automatic wait_words();
    while (rx_idx < PAD_SLOTS + 2 * N_VEC + EXTRA) @(posedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  initial begin
    rst = 1'b1; byte_valid = 1'b0; byte_data = 8'h00;
    repeat (3) @(posedge clk);
    #2;
    check(ws == 1'b0, "R9 reset ws", ws, 0);
    check(sdata == 1'b0, "R9 reset sdata", sdata, 0);
    check(byte_req == 1'b0, "R9 reset byte_req", byte_req, 0);
    check(sclk == 1'b0, "R1 sclk low while clk high", sclk, 0);
    #4;
    check(sclk == 1'b1, "R1 sclk high while clk low", sclk, 1);
    @(posedge clk); #2;
    rst = 1'b0;
    feed_table();
    wait_words();

    // Mid-stream reset, off a slot boundary
    repeat (13) @(posedge clk);
    #2; rst = 1'b1;
    @(posedge clk); #2;
    check(ws == 1'b0, "R9 mid reset ws", ws, 0);
    check(sdata == 1'b0, "R9 mid reset sdata", sdata, 0);
    check(byte_req == 1'b0, "R9 mid reset byte_req", byte_req, 0);
    @(posedge clk); #2;
    rst = 1'b0;
    feed_table();
    wait_words();
    check(first_req_done, "R7 request seen after restart", first_req_done, 1);

    if (!done) begin
      done = 1'b1;
      summary();
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired rx_idx=%0d expected=%0d", rx_idx, PAD_SLOTS + 2 * N_VEC + EXTRA);
      summary();
      $finish;
    end
  end

endmodule